// File: doc/BRIEF.md
# Channel-Hopping Radio Command Sequencer

This block controls an external 2.4 GHz packet transceiver over a four-wire SPI master port. It sends one short command packet many times, on a rotating set of three RF channels. When reset is released, it first programs a fixed table of 16-bit configuration registers. It then waits for work.

A send request is a one-cycle `start` pulse followed by the payload on a byte stream. The first byte of the stream is a length. The data bytes follow, and the block keeps them in a local buffer. The block then does two things:

- It programs the two sync-word registers once.
- It runs a fixed burst script a set number of times. Each burst idles the radio, clears both radio FIFO pointers, writes the length-prefixed payload into the radio FIFO and starts a transmission on the next hop channel. A settable number of system clocks then passes, to cover the packet airtime, before the next burst.

The payload stream uses a valid/ready handshake. A byte moves on a rising clock edge where `pl_valid` and `pl_ready` are both high. The source may hold `pl_valid` low for any number of cycles, and must hold the byte steady while `pl_ready` is low. `pl_ready` is high only while the block is collecting the payload of a request it has accepted. `busy` is high while the block is configuring the radio or serving a request. `done` marks the end of a request.

Top module: `rf_burst_seq`

## Requirements
- R1: The SPI port uses clock polarity 0 and phase 1, and sends each byte MSB first:
  - `spi_sck` rests low whenever `spi_cs_n` is high.
  - `spi_mosi` changes only together with a rising `spi_sck`.
  - The receiver samples on the falling edge.
- R2: `spi_cs_n` stays low for exactly one whole transaction. Between two transactions it is high for at least two clock cycles.
- R3: A register write is one 3-byte transaction in this order: register address, high data byte, low data byte.
- R4: After reset, `busy` is high while the block writes 27 configuration registers, in ascending address order, with these values:
  - 00=6FE0, 01=5681, 02=6617, 04=9CC9, 05=6637, 07=004C, 08=6C90
  - 09=4800, 0A=7FFD, 0B=0008, 0C=0000, 0D=48BD
  - 16=00FF, 17=8005, 18=0067, 19=1659, 1A=19E0, 1B=1300, 1C=1800
  - 20=4800, 21=3FC7, 22=2000, 23=0300
  - 28=4402, 29=B000, 2A=FDB0, 2B=000F

  After the last of these writes, `busy` falls and no further SPI traffic occurs until a request arrives.
- R5: A `start` pulse while `busy` is high is ignored. It produces no extra transactions, no `pl_ready` and no extra `done`.
- R6: Payload stream rules:
  - Only after an accepted `start` is `pl_ready` raised.
  - The first byte transferred is the length. A length above MAX_LEN (default 8) is clamped to MAX_LEN.
  - Exactly the clamped number of data bytes is then taken, after which `pl_ready` is low.
- R7: Each request begins with two register writes, in this order: register 0x24 with SYNC_A (default 0x147A), then register 0x27 with SYNC_B (default 0x258B).
- R8: Each burst makes four transactions, in this order:
  - write register 0x07 = 0x0000;
  - write register 0x34 = 0x8080;
  - one FIFO frame: address FIFO_ADDR (default 0x32), the clamped length byte, then the stored data bytes in arrival order;
  - write register 0x07 with high byte 0x01 and the channel in the low 7 bits of the low byte.
- R9: The burst channels cycle 9, 40, 71, 9, and so on. Every request restarts at channel 9.
- R10: A request makes BURSTS (default 40) bursts. After the last one, `done` is high for exactly one cycle, in the same cycle that `busy` first reads low.
- R11: After each start-transmit write, at least AIR_CYC clock cycles pass between that frame's `spi_cs_n` rising and the next `spi_cs_n` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle send request |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte (length first, then data) |
| pl_ready | output | 1 | Block accepts a payload byte |
| busy | output | 1 | Configuring or serving a request |
| done | output | 1 | One-cycle pulse at end of a request |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to radio |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench decodes every SPI frame from the pins and compares it byte for byte with the script the requirements imply. It uses two payload patterns:

- A 7-byte command sent with bubbles in `pl_valid`. This shows that bytes are stored in arrival order, and it exposes any byte skipped or repeated under back-pressure.
- A length of 12 against a buffer of 8, with a ninth data byte kept on offer. This separates clamping of the length byte from overrun of the stream, because the extra byte must stay unaccepted.

Running two requests back to back shows whether the channel rotation and the sync-word writes restart for each request. Stray `start` pulses, sent during configuration and during a request, test that both phases ignore them.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

  localparam int CFG_N = 27;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] val;
  } reg_wr_t;

  typedef enum logic [3:0] {
    ST_CFG, ST_IDLE, ST_LOAD, ST_SYNC0, ST_SYNC3,
    ST_STOP, ST_CLR, ST_FIFO, ST_TX, ST_AIR
  } seq_state_t;

  // Power-up register table, ascending address order.
  function automatic reg_wr_t cfg_entry(input logic [4:0] idx);
    case (idx)
      5'd0:  return '{8'h00, 16'h6FE0};
      5'd1:  return '{8'h01, 16'h5681};
      5'd2:  return '{8'h02, 16'h6617};
      5'd3:  return '{8'h04, 16'h9CC9};
      5'd4:  return '{8'h05, 16'h6637};
      5'd5:  return '{8'h07, 16'h004C};
      5'd6:  return '{8'h08, 16'h6C90};
      5'd7:  return '{8'h09, 16'h4800};
      5'd8:  return '{8'h0A, 16'h7FFD};
      5'd9:  return '{8'h0B, 16'h0008};
      5'd10: return '{8'h0C, 16'h0000};
      5'd11: return '{8'h0D, 16'h48BD};
      5'd12: return '{8'h16, 16'h00FF};
      5'd13: return '{8'h17, 16'h8005};
      5'd14: return '{8'h18, 16'h0067};
      5'd15: return '{8'h19, 16'h1659};
      5'd16: return '{8'h1A, 16'h19E0};
      5'd17: return '{8'h1B, 16'h1300};
      5'd18: return '{8'h1C, 16'h1800};
      5'd19: return '{8'h20, 16'h4800};
      5'd20: return '{8'h21, 16'h3FC7};
      5'd21: return '{8'h22, 16'h2000};
      5'd22: return '{8'h23, 16'h0300};
      5'd23: return '{8'h28, 16'h4402};
      5'd24: return '{8'h29, 16'hB000};
      5'd25: return '{8'h2A, 16'hFDB0};
      5'd26: return '{8'h2B, 16'h000F};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/rfseq_spi_master.sv
module rfseq_spi_master #(
  parameter int HALF  = 2,
  parameter int GAP   = 2,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       byte_in,
  output logic [LEN_W-1:0] byte_idx,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n
);

  localparam int MAXC = (HALF > GAP) ? HALF : GAP;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {SP_IDLE, SP_SETUP, SP_HI, SP_LO, SP_GAP} sp_t;

  sp_t              st;
  logic [CW-1:0]    cnt;
  logic [2:0]       bitc;
  logic [LEN_W-1:0] bytec;
  logic [LEN_W-1:0] len_q;

  assign busy     = (st != SP_IDLE);
  assign byte_idx = bytec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SP_IDLE;
      cnt   <= '0;
      bitc  <= '0;
      bytec <= '0;
      len_q <= '0;
      sck   <= 1'b0;
      mosi  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SP_IDLE: if (start) begin
          cs_n  <= 1'b0;
          len_q <= len;
          bytec <= '0;
          bitc  <= '0;
          cnt   <= '0;
          st    <= SP_SETUP;
        end
        SP_SETUP: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sck  <= 1'b1;
            mosi <= byte_in[3'd7 - bitc];
            st   <= SP_HI;
          end else cnt <= cnt + 1'b1;
        end
        SP_HI: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            sck <= 1'b0;
            st  <= SP_LO;
          end else cnt <= cnt + 1'b1;
        end
        SP_LO: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (bitc == 3'd7) begin
              bitc <= '0;
              if (bytec == len_q - 1'b1) begin
                cs_n <= 1'b1;
                st   <= SP_GAP;
              end else begin
                bytec <= bytec + 1'b1;
                st    <= SP_SETUP;
              end
            end else begin
              bitc <= bitc + 1'b1;
              sck  <= 1'b1;
              mosi <= byte_in[3'd6 - bitc];
              st   <= SP_HI;
            end
          end else cnt <= cnt + 1'b1;
        end
        SP_GAP: begin
          if (cnt == CW'(GAP - 1)) begin
            cnt  <= '0;
            st   <= SP_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= SP_IDLE;
      endcase
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R1
  AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sck) |-> $stable(mosi)); // R1
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R2
  AST_CS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SP_HI || st == SP_LO) |-> !cs_n); // R2

endmodule

// File: rtl/rfseq_payload_buf.sv
module rfseq_payload_buf #(
  parameter int MAX_LEN = 8,
  parameter int PW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          full,
  output logic [PW-1:0] len,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  typedef enum logic [1:0] {PB_OFF, PB_LEN, PB_DATA} pb_t;

  pb_t           phase;
  logic [PW-1:0] cnt;
  logic [PW-1:0] len_q;
  logic [PW-1:0] len_clamped;
  logic [7:0]    mem [MAX_LEN];

  assign in_ready    = (phase != PB_OFF);
  assign len         = len_q;
  assign len_clamped = (in_data > 8'(MAX_LEN)) ? PW'(MAX_LEN) : PW'(in_data);
  assign rd_data     = (rd_idx < PW'(MAX_LEN)) ? mem[IW'(rd_idx)] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PB_OFF;
      cnt   <= '0;
      len_q <= '0;
      full  <= 1'b0;
    end else if (arm) begin
      phase <= PB_LEN;
      cnt   <= '0;
      full  <= 1'b0;
    end else begin
      case (phase)
        PB_LEN: if (in_valid) begin
          len_q <= len_clamped;
          cnt   <= '0;
          if (len_clamped == '0) begin
            phase <= PB_OFF;
            full  <= 1'b1;
          end else phase <= PB_DATA;
        end
        PB_DATA: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == len_q - 1'b1) begin
            phase <= PB_OFF;
            full  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (phase == PB_DATA && in_valid && !arm) mem[IW'(cnt)] <= in_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PB_DATA) |-> (cnt < len_q)); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= PW'(MAX_LEN)); // R6
  AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready); // R6

endmodule

// File: rtl/rfseq_ctrl.sv
module rfseq_ctrl
  import rfseq_pkg::*;
#(
  parameter int          BURSTS    = 40,
  parameter int          AIR_CYC   = 200,
  parameter logic [7:0]  FIFO_ADDR = 8'h32,
  parameter logic [15:0] SYNC_A    = 16'h147A,
  parameter logic [15:0] SYNC_B    = 16'h258B,
  parameter logic [6:0]  CH0       = 7'd9,
  parameter logic [6:0]  CH1       = 7'd40,
  parameter logic [6:0]  CH2       = 7'd71,
  parameter int          PW        = 4,
  parameter int          LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             buf_arm,
  input  logic             buf_full,
  input  logic [PW-1:0]    buf_len,
  output logic [PW-1:0]    buf_idx,
  input  logic [7:0]       buf_data,
  output logic             spi_start,
  output logic [LEN_W-1:0] spi_len,
  input  logic [LEN_W-1:0] spi_idx,
  output logic [7:0]       spi_byte,
  input  logic             spi_busy,
  input  logic             spi_done
);

  localparam int BW = (BURSTS > 1) ? $clog2(BURSTS) : 1;
  localparam int AW = $clog2(AIR_CYC + 2);

  seq_state_t    state, next_wr;
  logic [4:0]    cfg_idx;
  logic          inflight;
  logic [BW-1:0] burst;
  logic [1:0]    ch_sel;
  logic [AW-1:0] air_cnt;
  logic [6:0]    ch;
  reg_wr_t       wr;

  assign busy = (state != ST_IDLE);

  always_comb begin
    case (ch_sel)
      2'd0:    ch = CH0;
      2'd1:    ch = CH1;
      default: ch = CH2;
    endcase
  end

  always_comb begin
    case (state)
      ST_CFG:   wr = cfg_entry(cfg_idx);
      ST_SYNC0: wr = '{8'h24, SYNC_A};
      ST_SYNC3: wr = '{8'h27, SYNC_B};
      ST_STOP:  wr = '{8'h07, 16'h0000};
      ST_CLR:   wr = '{8'h34, 16'h8080};
      ST_TX:    wr = '{8'h07, {8'h01, 1'b0, ch}};
      default:  wr = '0;
    endcase
  end

  always_comb begin
    buf_idx = PW'(spi_idx - LEN_W'(2));
    if (state == ST_FIFO) begin
      spi_len = LEN_W'(buf_len) + LEN_W'(2);
      if (spi_idx == LEN_W'(0))      spi_byte = FIFO_ADDR;
      else if (spi_idx == LEN_W'(1)) spi_byte = 8'(buf_len);
      else                           spi_byte = buf_data;
    end else begin
      spi_len = LEN_W'(3);
      if (spi_idx == LEN_W'(0))      spi_byte = wr.addr;
      else if (spi_idx == LEN_W'(1)) spi_byte = wr.val[15:8];
      else                           spi_byte = wr.val[7:0];
    end
  end

  always_comb begin
    case (state)
      ST_CFG:   next_wr = (cfg_idx == 5'(CFG_N - 1)) ? ST_IDLE : ST_CFG;
      ST_SYNC0: next_wr = ST_SYNC3;
      ST_SYNC3: next_wr = ST_STOP;
      ST_STOP:  next_wr = ST_CLR;
      ST_CLR:   next_wr = ST_FIFO;
      ST_FIFO:  next_wr = ST_TX;
      ST_TX:    next_wr = ST_AIR;
      default:  next_wr = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CFG;
      cfg_idx   <= '0;
      inflight  <= 1'b0;
      burst     <= '0;
      ch_sel    <= '0;
      air_cnt   <= '0;
      spi_start <= 1'b0;
      done      <= 1'b0;
      buf_arm   <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      done      <= 1'b0;
      buf_arm   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LOAD;
          buf_arm <= 1'b1;
        end
        ST_LOAD: if (buf_full && !buf_arm) begin
          state  <= ST_SYNC0;
          burst  <= '0;
          ch_sel <= '0;
        end
        ST_AIR: begin
          if (air_cnt >= AW'(AIR_CYC)) begin
            if (burst == BW'(BURSTS - 1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              burst  <= burst + 1'b1;
              ch_sel <= (ch_sel == 2'd2) ? 2'd0 : ch_sel + 2'd1;
              state  <= ST_STOP;
            end
          end else air_cnt <= air_cnt + 1'b1;
        end
        default: begin
          if (!inflight) begin
            if (!spi_busy) begin
              spi_start <= 1'b1;
              inflight  <= 1'b1;
            end
          end else if (spi_done) begin
            inflight <= 1'b0;
            state    <= next_wr;
            if (state == ST_CFG) cfg_idx <= cfg_idx + 1'b1;
            if (state == ST_TX)  air_cnt <= '0;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_busy); // R2
  AST_CFG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx != $past(cfg_idx)) |-> (cfg_idx == 5'($past(cfg_idx) + 5'd1))); // R4

endmodule

// File: rtl/rf_burst_seq.sv
module rf_burst_seq #(
  parameter int          SCK_HALF  = 2,
  parameter int          CS_GAP    = 2,
  parameter int          MAX_LEN   = 8,
  parameter int          BURSTS    = 40,
  parameter int          AIR_CYC   = 200,
  parameter logic [7:0]  FIFO_ADDR = 8'h32,
  parameter logic [15:0] SYNC_A    = 16'h147A,
  parameter logic [15:0] SYNC_B    = 16'h258B,
  parameter logic [6:0]  CH0       = 7'd9,
  parameter logic [6:0]  CH1       = 7'd40,
  parameter logic [6:0]  CH2       = 7'd71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pl_valid,
  input  logic [7:0] pl_data,
  output logic       pl_ready,
  output logic       busy,
  output logic       done,
  output logic       spi_sck,
  output logic       spi_mosi,
  output logic       spi_cs_n
);

  localparam int PW    = $clog2(MAX_LEN + 1);
  localparam int LEN_W = $clog2(MAX_LEN + 3);

  logic             buf_arm, buf_full;
  logic [PW-1:0]    buf_len, buf_idx;
  logic [7:0]       buf_data;
  logic             spi_start, spi_busy, spi_done;
  logic [LEN_W-1:0] spi_len, spi_idx;
  logic [7:0]       spi_byte;

  rfseq_payload_buf #(.MAX_LEN(MAX_LEN), .PW(PW)) u_buf (
    .clk(clk), .rst_n(rst_n), .arm(buf_arm),
    .in_valid(pl_valid), .in_data(pl_data), .in_ready(pl_ready),
    .full(buf_full), .len(buf_len), .rd_idx(buf_idx), .rd_data(buf_data)
  );

  rfseq_ctrl #(
    .BURSTS(BURSTS), .AIR_CYC(AIR_CYC), .FIFO_ADDR(FIFO_ADDR),
    .SYNC_A(SYNC_A), .SYNC_B(SYNC_B), .CH0(CH0), .CH1(CH1), .CH2(CH2),
    .PW(PW), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .buf_arm(buf_arm), .buf_full(buf_full), .buf_len(buf_len),
    .buf_idx(buf_idx), .buf_data(buf_data),
    .spi_start(spi_start), .spi_len(spi_len), .spi_idx(spi_idx),
    .spi_byte(spi_byte), .spi_busy(spi_busy), .spi_done(spi_done)
  );

  rfseq_spi_master #(.HALF(SCK_HALF), .GAP(CS_GAP), .LEN_W(LEN_W)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(spi_start), .len(spi_len),
    .byte_in(spi_byte), .byte_idx(spi_idx), .busy(spi_busy),
    .done(spi_done), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );

endmodule

// File: tb/sim_rf_burst_seq.sv
module sim_rf_burst_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AIR        = 30;
  localparam int NBURST     = 40;
  localparam int MAXL       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pl_valid = 1'b0;
  logic [7:0] pl_data = 8'h00;
  logic pl_ready, busy, done, spi_sck, spi_mosi, spi_cs_n;

  int checks = 0;
  int errors = 0;

  rf_burst_seq #(.AIR_CYC(AIR), .BURSTS(NBURST), .MAX_LEN(MAXL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_ready(pl_ready), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // SPI frame monitor: samples on falling SCK, MSB first
  logic [7:0] q_b[$];
  int q_off[$], q_len[$], q_start[$], q_end[$];
  int cyc = 0;
  int cur_len = 0, nbit = 0;
  bit open = 0;
  logic [7:0] sh = 8'h00;
  int done_cnt = 0;
  bit done_prev = 0;
  int done_wide = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge spi_cs_n) begin
    open = 1; cur_len = 0; nbit = 0;
    q_off.push_back(q_b.size());
    q_start.push_back(cyc);
  end
  always @(posedge spi_cs_n) if (open) begin
    open = 0;
    q_len.push_back(cur_len);
    q_end.push_back(cyc);
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    nbit++;
    if (nbit == 8) begin q_b.push_back(sh); nbit = 0; cur_len++; end
  end
  always @(negedge clk) begin
    if (done === 1'b1) begin
      done_cnt++;
      if (done_prev) done_wide++;
      done_prev = 1;
    end else done_prev = 0;
  end

  logic [23:0] exp_cfg [27] = '{
    24'h006FE0, 24'h015681, 24'h026617, 24'h049CC9, 24'h056637, 24'h07004C,
    24'h086C90, 24'h094800, 24'h0A7FFD, 24'h0B0008, 24'h0C0000, 24'h0D48BD,
    24'h1600FF, 24'h178005, 24'h180067, 24'h191659, 24'h1A19E0, 24'h1B1300,
    24'h1C1800, 24'h204800, 24'h213FC7, 24'h222000, 24'h230300, 24'h284402,
    24'h29B000, 24'h2AFDB0, 24'h2B000F};

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R3: three-byte register write frame
  task automatic chk_wr(input int f, input logic [23:0] e, input string rq);
    chk(q_len[f] == 3, rq, "frame length", q_len[f], 3);
    if (q_len[f] == 3)
      chk({q_b[q_off[f]], q_b[q_off[f]+1], q_b[q_off[f]+2]} == e, rq, "write frame",
          int'({q_b[q_off[f]], q_b[q_off[f]+1], q_b[q_off[f]+2]}), int'(e));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R2", "cs_n in reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck in reset", spi_sck, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(pl_ready == 1'b0, "R6", "ready in reset", pl_ready, 0);
  endtask

  task automatic t_config();
    int gapbad = 0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R4", "busy during config", busy, 1);
    repeat (50) @(negedge clk);
    pulse_start(); // R5: ignored while configuring
    while (busy) @(negedge clk);
    chk(q_len.size() == 27, "R4", "config frame count", q_len.size(), 27);
    for (int i = 0; i < 27 && i < q_len.size(); i++) chk_wr(i, exp_cfg[i], "R4");
    for (int i = 1; i < q_len.size(); i++)
      if (q_start[i] - q_end[i-1] < 2) gapbad++;
    chk(gapbad == 0, "R2", "cs high gaps", gapbad, 0);
    repeat (200) @(negedge clk);
    chk(q_len.size() == 27, "R5", "no traffic after config", q_len.size(), 27);
    chk(pl_ready == 1'b0 && busy == 1'b0, "R5", "start ignored", {pl_ready, busy}, 0);
  endtask

  task automatic t_request(input logic [7:0] bytes[$], input int exp_len,
                           input bit offer_extra, input bit stray_start, input string tag);
    int f0 = q_len.size();
    int d0 = done_cnt;
    int f, bad_ch = 0, bad_air = 0, bad_fifo = 0;
    logic [23:0] txw;
    chk(pl_ready == 1'b0, "R6", {tag, " ready before start"}, pl_ready, 0);
    pulse_start();
    for (int i = 0; i < exp_len + 1; i++) begin
      pl_data = bytes[i]; pl_valid = 1'b1;
      while (!pl_ready) @(negedge clk);
      @(negedge clk);
      pl_valid = 1'b0;
      if (i % 2 == 1) @(negedge clk);
    end
    if (offer_extra) begin
      pl_data = bytes[exp_len + 1]; pl_valid = 1'b1;
      repeat (20) @(negedge clk);
      chk(pl_ready == 1'b0, "R6", {tag, " extra byte refused"}, pl_ready, 0);
      pl_valid = 1'b0;
    end
    if (stray_start) begin
      repeat (300) @(negedge clk);
      pulse_start(); // R5: ignored while sending
    end
    while (busy) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10", {tag, " done pulses"}, done_cnt - d0, 1);
    chk(done_wide == 0, "R10", {tag, " done width"}, done_wide, 0);
    chk(q_len.size() - f0 == 2 + 4*NBURST, "R10", {tag, " frame count"},
        q_len.size() - f0, 2 + 4*NBURST);
    if (q_len.size() - f0 != 2 + 4*NBURST) return;
    chk_wr(f0, 24'h24147A, "R7");
    chk_wr(f0 + 1, 24'h27258B, "R7");
    for (int b = 0; b < NBURST; b++) begin
      f = f0 + 2 + 4*b;
      if (q_len[f] != 3 || {q_b[q_off[f]], q_b[q_off[f]+1], q_b[q_off[f]+2]} != 24'h070000) bad_fifo++;
      if (q_len[f+1] != 3 || {q_b[q_off[f+1]], q_b[q_off[f+1]+1], q_b[q_off[f+1]+2]} != 24'h348080) bad_fifo++;
      if (q_len[f+2] != exp_len + 2 || q_b[q_off[f+2]] != 8'h32 || q_b[q_off[f+2]+1] != 8'(exp_len))
        bad_fifo++;
      else
        for (int k = 0; k < exp_len; k++)
          if (q_b[q_off[f+2]+2+k] != bytes[k+1]) bad_fifo++;
      txw = {8'h07, 8'h01, 1'b0, (b % 3 == 0) ? 7'd9 : (b % 3 == 1) ? 7'd40 : 7'd71};
      if (q_len[f+3] != 3 || {q_b[q_off[f+3]], q_b[q_off[f+3]+1], q_b[q_off[f+3]+2]} != txw) bad_ch++;
      if (b < NBURST - 1 && q_start[f+4] - q_end[f+3] < AIR) bad_air++;
    end
    chk(bad_fifo == 0, "R8", {tag, " burst stop/clear/fifo frames"}, bad_fifo, 0);
    chk(bad_ch == 0, "R9", {tag, " start-tx channel rotation"}, bad_ch, 0);
    chk(bad_air == 0, "R11", {tag, " airtime wait"}, bad_air, 0);
    chk_wr(f0 + 5, 24'h070109, "R9");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] p1[$] = '{8'h07, 8'hB8, 8'hFD, 8'h4D, 8'h00, 8'h00, 8'h01, 8'h06};
    logic [7:0] p2[$] = '{8'd12, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                          8'h77, 8'h88, 8'h99};
    t_reset();
    t_config();
    t_request(p1, 7, 1'b0, 1'b1, "R6 seven-byte");
    t_request(p2, MAXL, 1'b1, 1'b0, "R6 clamped");
    summary();
    $finish;
  end

endmodule